// File: doc/BRIEF.md
# Instruction prefetch queue with bus arbiter

This block fetches code bytes ahead of the execution unit and keeps them in a small FIFO queue. The address of the next code fetch is held in its own fetch-address register, which is separate from the execution PC. The core pops bytes from the head of the queue whenever it needs them. Because bytes may sit in the queue long before they are used, fetch order and execution order are decoupled, and software never sees the queue.

One byte-wide memory port serves two requesters: the prefetcher and the execution unit's data accesses. When both want the port in the same cycle, the prefetcher always gets it. The memory accepts a request when ready is high. It answers each accepted request with a read-valid pulse after a fixed latency, and only one transaction is outstanding at a time.

A change of flow (jump, call, return or interrupt) is signalled as a redirect carrying the target address. A redirect empties the queue, loads the target into the fetch-address register and marks any code fetch still in flight as stale. A stale fetch is thrown away when it returns.

Top module: `pfq_top`

## Requirements
- R1: While reset is asserted, the queue is empty (`q_valid_o` = 0, `q_level_o` = 0), `du_done_o` is 0, and the code fetch address on `mem_addr_o` equals the parameter `RESET_ADDR` (default 0).
- R2: A code fetch is requested only when the queue has a free entry. The level never exceeds `DEPTH` (default 4). With no pops, the queue fills to 4 bytes and no further memory request is made.
- R3: Each code fetch reads the address held in the fetch-address register. That register advances by one after each code byte that is accepted into the queue, so the core pops bytes in ascending address order starting from the last redirect target.
- R4: When a code fetch and a data request compete for an idle port, the code fetch is granted. A data read issued while the queue has room therefore completes only after the queue has been refilled to 4 bytes.
- R5: A redirect pulse empties the queue, so `q_valid_o` = 0 and `q_level_o` = 0 in the following cycle. The next byte popped is the byte at the redirect target.
- R6: A code fetch that is in flight when a redirect arrives is dropped when its data returns. None of its bytes ever reaches the queue.
- R7: A data request (`du_req_i` held high with stable address, write flag and write data) stays pending until it is granted. It finishes with a one-cycle `du_done_o`. For a read, `du_rdata_o` holds the memory byte in that cycle. A write (`du_we_i` = 1) updates memory, so later code fetches from that address return the written byte.
- R8: A pop and a queue refill in the same cycle leave `q_level_o` unchanged.
- R9: A pop while the queue is empty is ignored: the level does not underflow and no byte is skipped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pop_i | input | 1 | Core consumes the head byte |
| q_valid_o | output | 1 | Queue holds at least one byte |
| q_data_o | output | DW | Head byte of the queue |
| q_level_o | output | $clog2(DEPTH+1) | Number of bytes held |
| redirect_i | input | 1 | Change of flow, one-cycle pulse |
| redirect_addr_i | input | AW | Target address of the change of flow |
| du_req_i | input | 1 | Execution-unit data request, held until done |
| du_we_i | input | 1 | Data request is a write |
| du_addr_i | input | AW | Data request address |
| du_wdata_i | input | DW | Data write byte |
| du_done_o | output | 1 | Data request completes this cycle |
| du_rdata_o | output | DW | Data read byte, valid with du_done_o |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Memory write byte |
| mem_ready_i | input | 1 | Memory accepts the request this cycle |
| mem_rvalid_i | input | 1 | Memory response for the outstanding request |
| mem_rdata_i | input | DW | Memory response byte |

## Verification
The bench redirects a second time while a code fetch is still in flight. A design that let the stale byte into the queue would hand the core a byte from the old target first. It raises a data read one cycle after a pop frees a slot. A design that favoured data accesses would finish that read with the queue below 4 bytes. It times a pop to land on the cycle a code byte returns, and it pops an empty queue right after a redirect. A counter that mishandled either case would show a changed level, or a byte skipped or repeated in the popped stream. Finally, it streams from several targets, one of them wrapping across the low address byte, and reads back a written location through a code fetch. A fetch register that stepped wrongly, or a write that never landed, would break the expected byte sequence.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  typedef enum logic {
    OWN_CODE = 1'b0,
    OWN_DATA = 1'b1
  } bus_owner_e;
endpackage

// File: rtl/pfq_queue.sv
module pfq_queue #(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] count_o
);
  logic [DW-1:0] store_q [DEPTH];
  logic [PW-1:0] rd_ptr_q, wr_ptr_q;
  logic [CW-1:0] count_q;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_pop  = pop_i && (count_q != '0) && !flush_i;
  assign do_push = push_i && !flush_i && ((count_q < CW'(DEPTH)) || do_pop);

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk_i) begin
      if (do_push && (wr_ptr_q == PW'(i))) store_q[i] <= push_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush_i) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign valid_o = (count_q != '0);
  assign data_o  = store_q[rd_ptr_q];
  assign count_o = count_q;

  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> ((count_q < CW'(DEPTH)) || pop_i || flush_i));

  assert_level_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !flush_i && count_q != '0) |=> (count_q == $past(count_q)));

  assert_flush_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (count_q == '0));

  assert_empty_pop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !flush_i && count_q == '0) |=> (count_q == '0));
endmodule

// File: rtl/pfq_fetch.sv
module pfq_fetch #(
  parameter int          AW         = 16,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          redirect_i,
  input  logic [AW-1:0] redirect_addr_i,
  input  logic          advance_i,
  output logic [AW-1:0] pc_o
);
  logic [AW-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pc_q <= RESET_ADDR;
    else if (redirect_i) pc_q <= redirect_addr_i;
    else if (advance_i)  pc_q <= pc_q + 1'b1;
  end

  assign pc_o = pc_q;

  assert_redirect_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |=> (pc_q == $past(redirect_addr_i)));

  assert_advance_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && !redirect_i) |=> (pc_q == $past(pc_q) + 1'b1));
endmodule

// File: rtl/pfq_arb.sv
module pfq_arb
  import pfq_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] q_count_i,
  input  logic [AW-1:0] fetch_pc_i,
  input  logic          redirect_i,
  input  logic          du_req_i,
  input  logic          du_we_i,
  input  logic [AW-1:0] du_addr_i,
  input  logic [DW-1:0] du_wdata_i,
  output logic          du_done_o,
  output logic [DW-1:0] du_rdata_o,
  output logic          code_push_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ready_i,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i
);
  logic       busy_q, stale_q, hold_q;
  bus_owner_e owner_q, hold_owner_q;
  logic       pf_want, sel_code, req, accept;

  assign pf_want = (q_count_i < CW'(DEPTH)) && !redirect_i;

  // a request waiting for ready keeps its owner; a waiting code fetch dies on redirect
  always_comb begin
    sel_code = 1'b0;
    req      = 1'b0;
    if (hold_q) begin
      sel_code = (hold_owner_q == OWN_CODE);
      req      = sel_code ? !redirect_i : 1'b1;
    end else if (!busy_q) begin
      sel_code = pf_want;
      req      = pf_want || du_req_i;
    end
  end

  assign accept      = req && mem_ready_i;
  assign mem_req_o   = req;
  assign mem_we_o    = !sel_code && du_we_i;
  assign mem_addr_o  = sel_code ? fetch_pc_i : du_addr_i;
  assign mem_wdata_o = du_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q       <= 1'b0;
      stale_q      <= 1'b0;
      hold_q       <= 1'b0;
      owner_q      <= OWN_CODE;
      hold_owner_q <= OWN_CODE;
    end else begin
      if (accept) begin
        busy_q  <= 1'b1;
        stale_q <= 1'b0;
        owner_q <= sel_code ? OWN_CODE : OWN_DATA;
        hold_q  <= 1'b0;
      end else begin
        hold_q       <= req;
        hold_owner_q <= sel_code ? OWN_CODE : OWN_DATA;
        if (busy_q && mem_rvalid_i) begin
          busy_q  <= 1'b0;
          stale_q <= 1'b0;
        end else if (busy_q && owner_q == OWN_CODE && redirect_i) begin
          stale_q <= 1'b1;
        end
      end
    end
  end

  assign code_push_o = busy_q && mem_rvalid_i && (owner_q == OWN_CODE) && !stale_q && !redirect_i;
  assign du_done_o   = busy_q && mem_rvalid_i && (owner_q == OWN_DATA);
  assign du_rdata_o  = mem_rdata_i;

  assert_pf_priority_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !hold_q && pf_want && du_req_i) |-> (mem_req_o && !mem_we_o && mem_addr_o == fetch_pc_i));

  assert_req_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i && !redirect_i && !(sel_code && !du_req_i && 1'b0)) |=>
    ((mem_req_o || redirect_i) && (!mem_req_o || $stable(mem_addr_o))));

  assert_stale_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && owner_q == OWN_CODE && redirect_i && !mem_rvalid_i) |=> !code_push_o);

  assert_one_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    du_done_o |=> !du_done_o);
endmodule

// File: rtl/pfq_top.sv
module pfq_top #(
  parameter int            AW         = 16,
  parameter int            DW         = 8,
  parameter int            DEPTH      = 4,
  parameter logic [AW-1:0] RESET_ADDR = '0,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pop_i,
  output logic          q_valid_o,
  output logic [DW-1:0] q_data_o,
  output logic [CW-1:0] q_level_o,
  input  logic          redirect_i,
  input  logic [AW-1:0] redirect_addr_i,
  input  logic          du_req_i,
  input  logic          du_we_i,
  input  logic [AW-1:0] du_addr_i,
  input  logic [DW-1:0] du_wdata_i,
  output logic          du_done_o,
  output logic [DW-1:0] du_rdata_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ready_i,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i
);
  logic [CW-1:0] count;
  logic [AW-1:0] fetch_pc;
  logic          code_push;

  pfq_queue #(.DW(DW), .DEPTH(DEPTH)) u_queue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (redirect_i),
    .push_i      (code_push),
    .push_data_i (mem_rdata_i),
    .pop_i       (pop_i),
    .valid_o     (q_valid_o),
    .data_o      (q_data_o),
    .count_o     (count)
  );

  pfq_fetch #(.AW(AW), .RESET_ADDR(RESET_ADDR)) u_fetch (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .redirect_i      (redirect_i),
    .redirect_addr_i (redirect_addr_i),
    .advance_i       (code_push),
    .pc_o            (fetch_pc)
  );

  pfq_arb #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_arb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .q_count_i    (count),
    .fetch_pc_i   (fetch_pc),
    .redirect_i   (redirect_i),
    .du_req_i     (du_req_i),
    .du_we_i      (du_we_i),
    .du_addr_i    (du_addr_i),
    .du_wdata_i   (du_wdata_i),
    .du_done_o    (du_done_o),
    .du_rdata_o   (du_rdata_o),
    .code_push_o  (code_push),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_ready_i  (mem_ready_i),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i)
  );

  assign q_level_o = count;

  assert_level_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_level_o <= CW'(DEPTH)) && (q_valid_o == (q_level_o != '0)));
endmodule

// File: tb/pfq_top_tb.sv
`timescale 1ns/1ps
module pfq_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pop_i = 1'b0;
  logic        q_valid_o;
  logic [7:0]  q_data_o;
  logic [2:0]  q_level_o;
  logic        redirect_i = 1'b0;
  logic [15:0] redirect_addr_i = '0;
  logic        du_req_i = 1'b0;
  logic        du_we_i = 1'b0;
  logic [15:0] du_addr_i = '0;
  logic [7:0]  du_wdata_i = '0;
  logic        du_done_o;
  logic [7:0]  du_rdata_o;
  logic        mem_req_o, mem_we_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic        mem_ready_i = 1'b1;
  logic        mem_rvalid_i;
  logic [7:0]  mem_rdata_i;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  pfq_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pop_i(pop_i), .q_valid_o(q_valid_o),
    .q_data_o(q_data_o), .q_level_o(q_level_o), .redirect_i(redirect_i),
    .redirect_addr_i(redirect_addr_i), .du_req_i(du_req_i), .du_we_i(du_we_i),
    .du_addr_i(du_addr_i), .du_wdata_i(du_wdata_i), .du_done_o(du_done_o),
    .du_rdata_o(du_rdata_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i)
  );

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] * 8'd7 + 8'd3;
  endfunction

  // memory model: three-edge response latency, one transaction at a time
  logic [7:0] mem [256];
  logic       p_v0, p_v1;
  logic [7:0] p_d0, p_d1;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(16'(i));
      p_v0 <= 1'b0; p_v1 <= 1'b0; p_d0 <= '0; p_d1 <= '0;
      mem_rvalid_i <= 1'b0; mem_rdata_i <= '0;
    end else begin
      p_v0 <= mem_req_o && mem_ready_i;
      p_d0 <= mem_we_o ? 8'h00 : mem[mem_addr_o[7:0]];
      if (mem_req_o && mem_ready_i && mem_we_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;
      p_v1 <= p_v0; p_d1 <= p_d0;
      mem_rvalid_i <= p_v1; mem_rdata_i <= p_d1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000 cycles", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pop_check(input logic [7:0] exp, input string req);
    int w = 0;
    while (!q_valid_o && w < 60) begin @(negedge clk); w++; end
    chk(req, {24'h0, q_data_o}, {24'h0, exp});
    pop_i = 1'b1;
    @(negedge clk);
    pop_i = 1'b0;
  endtask

  task automatic redirect(input logic [15:0] a);
    redirect_i = 1'b1;
    redirect_addr_i = a;
    @(negedge clk);
    redirect_i = 1'b0;
    chk("R5 flush", {28'h0, q_valid_o, q_level_o}, 32'h0);
  endtask

  task automatic wait_full();
    int w = 0;
    while (q_level_o != 3'd4 && w < 80) begin @(negedge clk); w++; end
  endtask

  // {target, pops, gap cycles}
  localparam logic [31:0] VECS [7] = '{
    32'h0010_05_00, 32'h00FE_06_01, 32'h1234_03_03, 32'h0020_08_00,
    32'h0055_01_00, 32'h0077_0A_02, 32'h0300_04_05
  };

  initial begin
    logic [15:0] tgt;
    int          reqs;
    logic [2:0]  lvl;
    int          w;

    repeat (3) @(negedge clk);
    chk("R1 valid", {31'h0, q_valid_o}, 0);
    chk("R1 level", {29'h0, q_level_o}, 0);
    chk("R1 addr", {16'h0, mem_addr_o}, 0);
    chk("R1 done", {31'h0, du_done_o}, 0);
    rst_n = 1'b1;

    // R2: fill without pops, then no further requests
    repeat (30) @(negedge clk);
    chk("R2 full level", {29'h0, q_level_o}, 4);
    reqs = 0;
    for (int i = 0; i < 12; i++) begin
      if (mem_req_o) reqs++;
      @(negedge clk);
    end
    chk("R2 no request when full", reqs, 0);
    for (int i = 0; i < 6; i++) pop_check(pat(16'(i)), "R3 reset stream");

    // R3: vector table of redirect targets and pop patterns
    for (int v = 0; v < 7; v++) begin
      tgt = VECS[v][31:16];
      redirect(tgt);
      for (int k = 0; k < int'(VECS[v][15:8]); k++) begin
        pop_check(pat(tgt + 16'(k)), "R3 stream");
        repeat (int'(VECS[v][7:0])) @(negedge clk);
      end
    end

    // R6: redirect while a code fetch is in flight
    redirect(16'h0040);
    w = 0;
    while (!(mem_req_o && !mem_we_o && mem_addr_o == 16'h0040) && w < 60) begin
      @(negedge clk); w++;
    end
    @(negedge clk);
    redirect(16'h00C0);
    for (int k = 0; k < 3; k++) pop_check(pat(16'h00C0 + 16'(k)), "R6 stale dropped");

    // R4: data read competes with prefetch after a pop frees a slot
    wait_full();
    pop_check(pat(16'h00C3), "R3 after stale");
    du_req_i = 1'b1; du_we_i = 1'b0; du_addr_i = 16'h0066;
    w = 0;
    while (!du_done_o && w < 80) begin @(negedge clk); w++; end
    chk("R4 queue refilled first", {29'h0, q_level_o}, 4);
    chk("R7 read data", {24'h0, du_rdata_o}, {24'h0, pat(16'h0066)});
    du_req_i = 1'b0;
    @(negedge clk);

    // R8: pop lands on refill cycle
    redirect(16'h0030);
    wait_full();
    pop_check(pat(16'h0030), "R8 lead");
    w = 0;
    while (!mem_rvalid_i && w < 60) begin @(negedge clk); w++; end
    lvl = q_level_o;
    chk("R8 head", {24'h0, q_data_o}, {24'h0, pat(16'h0031)});
    pop_i = 1'b1;
    @(negedge clk);
    pop_i = 1'b0;
    chk("R8 level unchanged", {29'h0, q_level_o}, {29'h0, lvl});
    for (int k = 2; k < 6; k++) pop_check(pat(16'h0030 + 16'(k)), "R8 stream");

    // R9: pop on empty queue right after redirect
    redirect(16'h00A0);
    chk("R9 empty before pop", {31'h0, q_valid_o}, 0);
    pop_i = 1'b1;
    @(negedge clk);
    pop_i = 1'b0;
    for (int k = 0; k < 5; k++) pop_check(pat(16'h00A0 + 16'(k)), "R9 no skip");

    // R7: write then fetch it as code
    du_req_i = 1'b1; du_we_i = 1'b1; du_addr_i = 16'h0090; du_wdata_i = 8'hC3;
    w = 0;
    while (!du_done_o && w < 80) begin @(negedge clk); w++; end
    chk("R7 write done", {31'h0, du_done_o}, 1);
    du_req_i = 1'b0; du_we_i = 1'b0;
    @(negedge clk);
    redirect(16'h0090);
    pop_check(8'hC3, "R7 written byte");
    pop_check(pat(16'h0091), "R7 next byte");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule